// File: doc/BRIEF.md
# One-Hot Configuration Address Translator

This block sits between a CPU-side load/store port and a PCI-side configuration request port. A CPU access that lands in a 4 MiB configuration window is turned into a configuration read or write. Inside the window, the address bits above the register offset are a set of one-hot device select lines rather than a binary bus/device/function field. The block scans those lines upward from the lowest one. The position of the first set line becomes a binary device number, which is placed above the unchanged register offset.

Accesses are one, two or four bytes wide and little-endian. Byte enables and write-data lanes come from the access size and the two low address bits. Read data is shifted back down to bit 0. The block handles one access at a time. The CPU hands over a request with a valid/ready handshake and sees a one-cycle completion pulse. An access that falls outside the window completes without reaching the PCI side. When the PCI side reports that nobody answered, a read returns all ones and a write completes with no further effect.

Top module: `cfgwin_xlate`

## Requirements
- R1: An accepted access whose address lies in [WIN_BASE, WIN_BASE + 4 MiB) produces exactly one configuration request. An access outside that range produces none, completes with `cpu_done`, and returns 32'hFFFF_FFFF when it is a read.
- R2: Bits 10:0 of the configuration address equal bits 10:0 of the CPU address.
- R3: Bits 14:11 of the configuration address hold the index (0 to 10) of the lowest set bit among CPU address bits 21:11. When several of those bits are set, the lowest one wins and no error is raised.
- R4: When CPU address bits 21:11 are all zero, the device number in configuration address bits 14:11 is 11.
- R5: `cpu_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2). `cfg_byte_en` is 4'b0001, 4'b0011 or 4'b1111 respectively, shifted left by CPU address bits 1:0.
- R6: Write data is little-endian. Byte k of `cpu_wdata` appears on lane (k + addr[1:0]) of `cfg_wdata`.
- R7: For a read that is answered (`cfg_rsp_hit`=1), `cpu_rdata` is the response shifted right by 8*addr[1:0], with the bits above the access size forced to zero.
- R8: A response with `cfg_rsp_hit`=0 makes a read return 32'hFFFF_FFFF. A write in that case completes normally.
- R9: While `cfg_req_valid` is high and `cfg_req_ready` is low, the request stays valid and its address, byte enables and write data stay unchanged.
- R10: `cpu_ready` is low from acceptance until completion. `cpu_done` is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Write value, right-justified |
| cpu_done | output | 1 | Access completion pulse |
| cpu_rdata | output | 32 | Read value, right-justified, valid with cpu_done |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | PCI side accepts the request |
| cfg_req_write | output | 1 | Configuration write when high |
| cfg_req_addr | output | 15 | Device number (14:11) and register offset (10:0) |
| cfg_byte_en | output | 4 | Active byte lanes |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Configuration response |
| cfg_rsp_hit | input | 1 | 0 = no target answered |
| cfg_rsp_rdata | input | 32 | Lane-aligned read data |

## Verification
The assertions assume that the PCI side raises `cfg_rsp_valid` only once per request, after the request has been taken. They also assume that `cpu_size` never takes the reserved code 3 and that accesses never cross a 32-bit word, so the byte-enable population is always 1, 2 or 4. The bench's responder answers only after it has taken a request, and every directed access uses aligned addresses with one of the three legal size codes. The responder can also hold off `cfg_req_ready` for a few cycles, so the hold rule is exercised under backpressure.

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int OFS_BITS = 11,
  parameter int SEL_LINES = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic        cpu_write,
  input  logic [31:0] cpu_addr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_done,
  output logic [31:0] cpu_rdata,
  output logic        cfg_req_valid,
  input  logic        cfg_req_ready,
  output logic        cfg_req_write,
  output logic [14:0] cfg_req_addr,
  output logic [3:0]  cfg_byte_en,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rsp_valid,
  input  logic        cfg_rsp_hit,
  input  logic [31:0] cfg_rsp_rdata
);
  localparam int WIN_BITS = OFS_BITS + SEL_LINES;
  localparam int DEV_W = $clog2(SEL_LINES + 1);

  typedef enum logic [1:0] {IDLE, REQ, WAIT, DONE} st_t;
  st_t st;

  logic [31:0] a_q, wd_q, rd_q;
  logic [1:0]  sz_q;
  logic        we_q;
  logic [DEV_W-1:0] dev;
  logic [3:0]  size_mask;
  logic [31:0] rsp_shift, rsp_mask;

  wire in_win = (cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
  wire [4:0] lane_sh = {a_q[1:0], 3'b000};

  always_comb begin
    dev = DEV_W'(SEL_LINES);
    for (int i = SEL_LINES - 1; i >= 0; i--)
      if (a_q[OFS_BITS + i]) dev = DEV_W'(i);
  end

  always_comb begin
    case (sz_q)
      2'd0:    begin size_mask = 4'b0001; rsp_mask = 32'h0000_00FF; end
      2'd1:    begin size_mask = 4'b0011; rsp_mask = 32'h0000_FFFF; end
      default: begin size_mask = 4'b1111; rsp_mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign rsp_shift     = cfg_rsp_rdata >> lane_sh;
  assign cpu_ready     = (st == IDLE);
  assign cpu_done      = (st == DONE);
  assign cpu_rdata     = rd_q;
  assign cfg_req_valid = (st == REQ);
  assign cfg_req_write = we_q;
  assign cfg_req_addr  = 15'({dev, a_q[OFS_BITS-1:0]});
  assign cfg_byte_en   = size_mask << a_q[1:0];
  assign cfg_wdata     = wd_q << lane_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      a_q  <= '0;
      wd_q <= '0;
      rd_q <= '0;
      sz_q <= '0;
      we_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (cpu_valid) begin
          a_q  <= cpu_addr;
          wd_q <= cpu_wdata;
          sz_q <= cpu_size;
          we_q <= cpu_write;
          if (in_win) begin
            st <= REQ;
          end else begin
            rd_q <= cpu_write ? 32'h0 : 32'hFFFF_FFFF;
            st   <= DONE;
          end
        end
        REQ:  if (cfg_req_ready) st <= WAIT;
        WAIT: if (cfg_rsp_valid) begin
          if (we_q)             rd_q <= 32'h0;
          else if (!cfg_rsp_hit) rd_q <= 32'hFFFF_FFFF;
          else                  rd_q <= rsp_shift & rsp_mask;
          st <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module cfgwin_xlate_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_ready,
  input logic        cpu_write,
  input logic [31:0] cpu_addr,
  input logic        cpu_done,
  input logic [31:0] cpu_rdata,
  input logic        cfg_req_valid,
  input logic        cfg_req_ready,
  input logic [14:0] cfg_req_addr,
  input logic [3:0]  cfg_byte_en,
  input logic [31:0] cfg_wdata,
  input logic        cfg_rsp_valid,
  input logic        cfg_rsp_hit
);
  logic [31:0] cap_addr;
  logic        cap_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_we   <= 1'b0;
    end else if (cpu_valid && cpu_ready) begin
      cap_addr <= cpu_addr;
      cap_we   <= cpu_write;
    end
  end

  a_r1_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cap_addr[31:22] == WIN_BASE[31:22]));
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_addr[10:0] == cap_addr[10:0]));
  a_r4_dev_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_addr[14:11] <= 4'd11));
  a_r5_be_pop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> ($countones(cfg_byte_en) == 1 || $countones(cfg_byte_en) == 2
                       || $countones(cfg_byte_en) == 4));
  a_r8_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsp_valid && !cfg_rsp_hit && !cap_we) |=> (cpu_done && cpu_rdata == 32'hFFFF_FFFF));
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=>
      (cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_byte_en) && $stable(cfg_wdata)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid || cpu_done) |-> !cpu_ready);
endmodule

bind cfgwin_xlate cfgwin_xlate_chk #(.WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
  .cpu_rdata(cpu_rdata), .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
  .cfg_req_addr(cfg_req_addr), .cfg_byte_en(cfg_byte_en), .cfg_wdata(cfg_wdata),
  .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_hit(cfg_rsp_hit)
);

// File: tb/cfgwin_xlate_test.sv
module cfgwin_xlate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [1:0] cpu_size = 0;
  logic cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic cfg_req_valid, cfg_req_write;
  logic cfg_req_ready = 0, cfg_rsp_valid = 0, cfg_rsp_hit = 0;
  logic [31:0] cfg_rsp_rdata = 0;
  logic [14:0] cfg_req_addr;
  logic [3:0] cfg_byte_en;
  logic [31:0] cfg_wdata;

  int checks = 0, fails = 0, cycles = 0;
  int req_seen = 0;
  int resp_delay = 0;
  logic resp_hit = 1;
  logic [31:0] resp_data = 0;
  logic [14:0] seen_addr, first_addr;
  logic [3:0] seen_be;
  logic [31:0] seen_wdata;
  logic seen_write;

  always #2 clk = ~clk;

  cfgwin_xlate uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial forever begin
    @(negedge clk);
    if (cfg_req_valid) begin
      first_addr = cfg_req_addr;
      for (int i = 0; i < resp_delay; i++) @(negedge clk);
      seen_addr = cfg_req_addr; seen_be = cfg_byte_en;
      seen_wdata = cfg_wdata; seen_write = cfg_req_write;
      req_seen++;
      cfg_req_ready = 1;
      @(negedge clk);
      cfg_req_ready = 0;
      cfg_rsp_valid = 1; cfg_rsp_hit = resp_hit; cfg_rsp_rdata = resp_data;
      @(negedge clk);
      cfg_rsp_valid = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_valid = 1; cpu_write = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 0;
    while (!cpu_done) @(negedge clk);
    rd = cpu_rdata;
  endtask

  task automatic t_reset();
    chk("R10 reset ready", 32'(cpu_ready), 1);
    chk("R10 reset done", 32'(cpu_done), 0);
    chk("R1 reset req", 32'(cfg_req_valid), 0);
  endtask

  task automatic t_dev(input logic [31:0] a, input logic [3:0] dev, input string tag);
    logic [31:0] rd;
    int n0 = req_seen;
    resp_hit = 1; resp_data = 32'h1234_5678;
    access(0, a, 2, 0, rd);
    chk({tag, " R1 one request"}, 32'(req_seen - n0), 1);
    chk({tag, " R3 device"}, 32'(seen_addr[14:11]), 32'(dev));
    chk({tag, " R2 offset"}, 32'(seen_addr[10:0]), 32'(a[10:0]));
    chk({tag, " R7 read word"}, rd, 32'h1234_5678);
  endtask

  task automatic t_outside();
    logic [31:0] rd;
    int n0 = req_seen;
    access(0, 32'h8000_0CF8, 2, 0, rd);
    chk("R1 outside read value", rd, 32'hFFFF_FFFF);
    access(1, 32'h80C0_0800, 2, 32'hAAAA_5555, rd);
    access(0, 32'h807F_FFFC, 2, 0, rd);
    chk("R1 outside no request", 32'(req_seen - n0), 0);
  endtask

  task automatic t_lanes();
    logic [31:0] rd;
    resp_hit = 1; resp_data = 32'hDDCC_BBAA;
    access(0, 32'h8080_1003, 0, 0, rd);
    chk("R5 be byte3", 32'(seen_be), 32'h8);
    chk("R7 read byte3", rd, 32'h0000_00DD);
    access(0, 32'h8080_1002, 1, 0, rd);
    chk("R5 be half2", 32'(seen_be), 32'hC);
    chk("R7 read half2", rd, 32'h0000_DDCC);
    access(1, 32'h8080_1001, 0, 32'h0000_0077, rd);
    chk("R5 be byte1", 32'(seen_be), 32'h2);
    chk("R6 wdata byte1", seen_wdata[15:8], 32'h77);
    chk("R6 write flag", 32'(seen_write), 1);
    access(1, 32'h8080_1002, 1, 32'h0000_BEEF, rd);
    chk("R6 wdata half2", seen_wdata[31:16], 32'hBEEF);
    access(1, 32'h8080_1000, 2, 32'h0102_0304, rd);
    chk("R5 be word", 32'(seen_be), 32'hF);
    chk("R6 wdata word", seen_wdata, 32'h0102_0304);
  endtask

  task automatic t_miss();
    logic [31:0] rd;
    int n0 = req_seen;
    resp_hit = 0; resp_data = 32'h0;
    access(0, 32'h8080_2000, 0, 0, rd);
    chk("R8 miss read ones", rd, 32'hFFFF_FFFF);
    access(1, 32'h8080_2004, 2, 32'h5A5A_5A5A, rd);
    chk("R8 miss write completes", 32'(req_seen - n0), 2);
    resp_hit = 1;
  endtask

  task automatic t_backpressure();
    logic [31:0] rd;
    resp_delay = 3; resp_hit = 1; resp_data = 32'h0;
    access(1, 32'h8084_0006, 1, 32'h0000_CAFE, rd);
    chk("R9 addr held", 32'(seen_addr), 32'(first_addr));
    chk("R9 device under hold", 32'(seen_addr[14:11]), 32'd7);
    chk("R9 wdata held", seen_wdata, 32'hCAFE_0000);
    resp_delay = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_dev(32'h8080_0804, 4'd0,  "bit11");
    t_dev(32'h8081_0008, 4'd5,  "bit16");
    t_dev(32'h80A0_0010, 4'd10, "bit21");
    t_dev(32'h8080_07FC, 4'd11, "R4 none");
    t_dev(32'h80A5_1000, 4'd1,  "multi");
    t_outside();
    t_lanes();
    t_miss();
    t_backpressure();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule